// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This unit compares two 64-bit IEEE-754 binary64 operands and reduces the result to a single condition bit. A 4-bit predicate selects which of the four possible relations (greater, less, equal, unordered) make the condition true. The low predicate bit has a second role: it also makes a quiet NaN raise the invalid-operation condition. A signaling NaN always raises it.

When invalid is raised, a trap-enable input chooses what happens. With the trap enabled, the unit pulses a trap request. With the trap disabled, it sets a sticky invalid flag, which holds until the clear input is pulsed. In both cases the condition bit still takes the predicate's unordered term.

The unit samples its operands when `in_valid` is high and presents the registered result one cycle later. Infinities take part in the normal ordered comparison. Positive zero and negative zero compare equal.

Top module: `fcmp_dbl_unit`

## Requirements
- R1: An operand is a NaN when its 11-bit exponent (bits 62:52) is all ones and its 52-bit mantissa (bits 51:0) is nonzero. An all-ones exponent with a zero mantissa is an infinity, and infinities are ordered against every non-NaN value by sign and magnitude.
- R2: The predicate encoding is: bit 3 = true on greater, bit 2 = true on less, bit 1 = true on equal, bit 0 = true on unordered. `cbit` is 1 exactly when the predicate bit of the single resulting relation (operand A relative to operand B) is set.
- R3: A NaN whose mantissa bit 51 is 1 (default polarity) is signaling. If either operand is a signaling NaN, invalid is raised whatever the predicate.
- R4: If either operand is a NaN, the relation is unordered. When predicate bit 0 is 1, any NaN raises invalid. When no NaN is signaling and predicate bit 0 is 0, invalid is not raised.
- R5: When invalid is raised and `trap_en` is 1, `trap` is 1 for that result, `cbit` equals predicate bit 0, and the invalid flag is not set by that operation. `trap` is 0 whenever invalid is not raised.
- R6: When invalid is raised and `trap_en` is 0, `invalid_flag` becomes 1 and stays 1, `trap` stays 0, and `cbit` equals predicate bit 0.
- R7: A `flag_clr` pulse clears `invalid_flag` one cycle later. If a new invalid event without trap is sampled in the same cycle, the flag is set instead.
- R8: When the signs differ, +0 against -0 is equal. Any other pair orders the negative operand as the lesser one.
- R9: When both operands are positive, the larger unsigned bit pattern is the greater value. Bit-identical operands are equal.
- R10: When both operands are negative, the ordering is reversed: the larger bit pattern is the lesser value. Bit-identical operands are equal.
- R11: `out_valid` is `in_valid` delayed by one cycle. While no input is sampled, `cbit` holds its last value and `trap` is 0.
- R12: A synchronous active-low reset clears `out_valid`, `cbit`, `invalid_flag` and `trap`, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are sampled this cycle |
| op_a | input | 64 | Left operand, binary64 |
| op_b | input | 64 | Right operand, binary64 |
| pred | input | 4 | Relation-select predicate |
| trap_en | input | 1 | Turns invalid into a trap request |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result registered this cycle |
| cbit | output | 1 | Condition bit |
| invalid_flag | output | 1 | Sticky invalid-operation flag |
| trap | output | 1 | Invalid trap request, one cycle per result |

## Verification
The hardest situation to reach from the ports is a flag clear that arrives in the same cycle as a new untrapped invalid event. Reaching it also requires the flag to be seen both surviving and not surviving across a mixed stream of trapped and untrapped NaN operations. The sweep drives every pair from a set of sixteen special encodings (both zeros, denormals, ±1 and its neighbour, the largest finites, both infinities, quiet and signaling NaNs of both signs) under all sixteen predicates, with the trap both on and off. A clear pulse is raised on a fixed stride, so it lands on many of these pairs. Random operands with a biased all-ones exponent then add further NaN collisions. The bench keeps its own sticky-flag model throughout.

// File: rtl/fcmp_pkg.sv
// Shared types for the binary64 comparator.
// Holds the relation encoding and the predicate bit positions; assumes a
// 4-bit predicate whose bit order is fixed by the consumers of cbit.
package fcmp_pkg;

    typedef enum logic [1:0] {
        REL_UN = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_GT = 2'd3
    } rel_e;

    parameter int PB_UN = 0;
    parameter int PB_EQ = 1;
    parameter int PB_LT = 2;
    parameter int PB_GT = 3;

    // Select the predicate term that matches the resolved relation.
    function automatic logic pred_hit(input logic [3:0] p, input rel_e r);
        logic hit;
        case (r)
            REL_GT:  hit = p[PB_GT];
            REL_LT:  hit = p[PB_LT];
            REL_EQ:  hit = p[PB_EQ];
            default: hit = p[PB_UN];
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
// Operand classifier.
// Decodes one floating-point word into NaN, signaling-NaN and zero
// indications. Assumes IEEE layout: sign at the top, then EXP_W exponent
// bits, then MAN_W mantissa bits. SNAN_POL is the value of the top
// mantissa bit that marks a NaN as signaling.
module fcmp_classify #(
    parameter int EXP_W    = 11,
    parameter int MAN_W    = 52,
    parameter bit SNAN_POL = 1'b1,
    localparam int W       = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] word,
    output logic         is_nan,
    output logic         is_snan,
    output logic         is_zero
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = word[W-2 -: EXP_W];
    assign man_f = word[MAN_W-1:0];

    // Classify the operand from its exponent and mantissa fields.
    always_comb begin
        is_nan  = (&exp_f) && (|man_f);
        is_snan = is_nan && (man_f[MAN_W-1] == SNAN_POL);
        is_zero = ~(|exp_f) && ~(|man_f);
    end

endmodule

// File: rtl/fcmp_order.sv
// Ordered-relation resolver.
// Returns less, equal or greater for two non-NaN operands, using the
// sign-magnitude property of the IEEE encoding. Assumes NaNs are filtered
// by the caller; the result for a NaN input is meaningless.
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_zero,
    input  logic         b_zero,
    output rel_e         rel
);

    logic a_neg;
    logic b_neg;
    logic mag_lt;

    assign a_neg  = a[W-1];
    assign b_neg  = b[W-1];
    assign mag_lt = a[W-2:0] < b[W-2:0];

    // Pick the relation: sign split first, then magnitude with sign-based sense.
    always_comb begin
        if (a_neg != b_neg) begin
            if (a_zero && b_zero) rel = REL_EQ;
            else if (a_neg)       rel = REL_LT;
            else                  rel = REL_GT;
        end else if (a == b) begin
            rel = REL_EQ;
        end else if (!a_neg) begin
            rel = mag_lt ? REL_LT : REL_GT;
        end else begin
            rel = mag_lt ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/fcmp_dbl_unit.sv
// Registered floating-point comparator, default binary64.
// Samples two operands, a 4-bit predicate and the trap enable when in_valid
// is high, and one cycle later presents the condition bit, a one-cycle trap
// request and a sticky invalid flag. Assumes the predicate bit 0 doubles as
// "quiet NaN raises invalid".
module fcmp_dbl_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W    = 11,
    parameter int MAN_W    = 52,
    parameter bit SNAN_POL = 1'b1,
    localparam int W       = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   pred,
    input  logic         trap_en,
    input  logic         flag_clr,
    output logic         out_valid,
    output logic         cbit,
    output logic         invalid_flag,
    output logic         trap
);

    localparam int NOPS = 2;

    logic [W-1:0] ops [NOPS];
    logic [NOPS-1:0] nan_v;
    logic [NOPS-1:0] snan_v;
    logic [NOPS-1:0] zero_v;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    genvar gi;
    generate
        for (gi = 0; gi < NOPS; gi++) begin : g_cls
            fcmp_classify #(
                .EXP_W   (EXP_W),
                .MAN_W   (MAN_W),
                .SNAN_POL(SNAN_POL)
            ) u_cls (
                .word   (ops[gi]),
                .is_nan (nan_v[gi]),
                .is_snan(snan_v[gi]),
                .is_zero(zero_v[gi])
            );
        end
    endgenerate

    rel_e ord_rel;

    fcmp_order #(.W(W)) u_order (
        .a     (op_a),
        .b     (op_b),
        .a_zero(zero_v[0]),
        .b_zero(zero_v[1]),
        .rel   (ord_rel)
    );

    logic any_nan;
    logic raise_inv;
    rel_e final_rel;
    logic hit;
    logic flag_next;

    // Merge NaN screening with the ordered relation and decide invalid.
    always_comb begin
        any_nan   = |nan_v;
        raise_inv = (|snan_v) || (any_nan && pred[PB_UN]);
        final_rel = any_nan ? REL_UN : ord_rel;
        hit       = pred_hit(pred, final_rel);
    end

    // Next sticky flag: clear first, a new untrapped invalid wins.
    always_comb begin
        flag_next = (flag_clr ? 1'b0 : invalid_flag)
                  | (in_valid && raise_inv && !trap_en);
    end

    // Result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            cbit         <= 1'b0;
            invalid_flag <= 1'b0;
            trap         <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            trap         <= in_valid && raise_inv && trap_en;
            invalid_flag <= flag_next;
            if (in_valid) cbit <= hit;
        end
    end

    assert_valid_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap && $stable(cbit)));

    assert_no_trap_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !trap_en) |=> !trap);

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !flag_clr) |=> invalid_flag);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> !invalid_flag);

    assert_zero_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_v[0] && zero_v[1]) |=> (cbit == $past(pred[PB_EQ])));

    assert_snan_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|snan_v)) |=> (trap || invalid_flag));

endmodule

// File: tb/fcmp_dbl_unit_test.sv
`timescale 1ns/1ps
module fcmp_dbl_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  pred = '0;
    logic        trap_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        out_valid, cbit, invalid_flag, trap;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_flag = 1'b0;
    logic last_c = 1'b0;

    always #4 clk = ~clk;

    fcmp_dbl_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .pred(pred), .trap_en(trap_en),
        .flag_clr(flag_clr), .out_valid(out_valid), .cbit(cbit),
        .invalid_flag(invalid_flag), .trap(trap)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] special(input int i);
        case (i)
            0:  return 64'h0000000000000000;
            1:  return 64'h8000000000000000;
            2:  return 64'h0000000000000001;
            3:  return 64'h8000000000000001;
            4:  return 64'h3FF0000000000000;
            5:  return 64'hBFF0000000000000;
            6:  return 64'h3FF0000000000001;
            7:  return 64'hBFF0000000000001;
            8:  return 64'h7FEFFFFFFFFFFFFF;
            9:  return 64'hFFEFFFFFFFFFFFFF;
            10: return 64'h7FF0000000000000;
            11: return 64'hFFF0000000000000;
            12: return 64'h7FF0000000000001;
            13: return 64'h7FF8000000000000;
            14: return 64'hFFF0000000000001;
            default: return 64'hFFFFFFFFFFFFFFFF;
        endcase
    endfunction

    function automatic logic is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
    endfunction

    function automatic logic is_inf(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] == 52'd0);
    endfunction

    function automatic string order_tag(input logic [63:0] a, input logic [63:0] b);
        if (is_nan(a) || is_nan(b)) return "R4";
        if (is_inf(a) || is_inf(b)) return "R1";
        if (a[63] != b[63])         return "R8";
        if (!a[63])                 return "R9";
        return "R10";
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [3:0] p, input logic te, input logic clr);
        logic na, nb, sa, sb, raise, ec, et;
        real ra, rb;
        string ot;
        na = is_nan(a);
        nb = is_nan(b);
        sa = na && a[51];
        sb = nb && b[51];
        raise = sa || sb || ((na || nb) && p[0]);
        if (na || nb) begin
            ec = p[0];
        end else begin
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
            ec = (ra > rb) ? p[3] : (ra < rb) ? p[2] : p[1];
        end
        et = raise && te;
        exp_flag = (clr ? 1'b0 : exp_flag) | (raise && !te);
        ot = (sa || sb) ? "R3" : order_tag(a, b);
        @(negedge clk);
        op_a = a; op_b = b; pred = p; trap_en = te; flag_clr = clr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b0;
        chk("R11", "out_valid", {63'd0, out_valid}, 64'd1);
        chk({ot, "/R2"}, "cbit", {63'd0, cbit}, {63'd0, ec});
        chk(raise ? (te ? "R5" : "R6") : "R5", "trap", {63'd0, trap}, {63'd0, et});
        chk(clr ? "R7" : "R6", "invalid_flag", {63'd0, invalid_flag}, {63'd0, exp_flag});
        last_c = ec;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R12: reset holds outputs low even with in_valid asserted.
        in_valid = 1'b1;
        op_a = 64'h7FF8000000000000;
        pred = 4'hF;
        trap_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12", "out_valid", {63'd0, out_valid}, 64'd0);
        chk("R12", "cbit", {63'd0, cbit}, 64'd0);
        chk("R12", "invalid_flag", {63'd0, invalid_flag}, 64'd0);
        chk("R12", "trap", {63'd0, trap}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Sweep of special encodings, all predicates, trap on and off.
        for (int te = 0; te < 2; te++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int p = 0; p < 16; p++) begin
                        run_op(special(i), special(j), 4'(p), te[0],
                               ((i * 16 + j + p) % 7) == 0);
                    end
                end
            end
        end

        // Random operands with biased NaN/infinity exponents and equal pairs.
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (($urandom % 4) == 0) a[62:52] = 11'h7FF;
            if (($urandom % 4) == 0) b[62:52] = 11'h7FF;
            if (($urandom % 6) == 0) b = a;
            if (($urandom % 6) == 0) b = {~a[63], a[62:0]};
            if (($urandom % 3) == 0) b[63] = a[63];
            run_op(a, b, 4'($urandom), 1'($urandom), (($urandom % 8) == 0));
        end

        // R11: idle cycles leave out_valid and trap low, cbit held.
        @(negedge clk);
        chk("R11", "idle out_valid", {63'd0, out_valid}, 64'd0);
        chk("R11", "idle trap", {63'd0, trap}, 64'd0);
        chk("R11", "idle cbit", {63'd0, cbit}, {63'd0, last_c});

        // R7: clear without a new event drops the flag.
        run_op(64'h7FF8000000000000, 64'd0, 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R7", "flag after clear", {63'd0, invalid_flag}, 64'd0);
        exp_flag = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule